// File: doc/BRIEF.md
# Windowed Byte Register File

This block is the 256-location byte register file of a small 8-bit controller core. Every access names a location either with a full 8-bit address (direct or indirect mode) or with a 4-bit working-register number. A working-register number is relocated through a pointer byte that the block holds. The upper nibble of the pointer picks one of 16 groups of 16 consecutive locations, and the instruction's nibble picks the register inside that group.

Besides the general-purpose storage, the block holds three control bytes at the top of the space: the pointer, a spare register and a stack-pointer byte. It enforces two access rules. The bank at 0xE0–0xEF cannot be reached by direct addressing. A protect window over 0x80–0xEF, enabled by an input bit, blocks reads and writes from every mode. A blocked read returns zero, a blocked write is dropped, and a one-cycle violation pulse reports either case. The core supplies one read port and one write port each cycle.

Top module: `wreg_file`

## Requirements
- R1: The mode code on each port is 2'b00 direct, 2'b01 working, 2'b10 indirect and 2'b11 reserved. In direct and indirect mode the effective address is the full 8-bit address.
- R2: In working mode the effective address is the pointer's bits [7:4] followed by bits [3:0] of the port address. This holds for all 16 groups.
- R3: The pointer byte is at 0xFD, the spare byte at 0xFE and the stack-pointer byte at 0xFF. All three read and write as whole bytes and are 0x00 after reset.
- R4: Storage at 0x00–0xFC is not cleared by reset and keeps its contents across a reset.
- R5: A direct-mode access whose address is in 0xE0–0xEF is blocked. The same locations are reachable in working and indirect mode.
- R6: When prot_en_i is 1, an access in any mode whose effective address is in 0x80–0xEF is blocked. 0x7F and 0xF0–0xFF stay open. When prot_en_i is 0, the window has no effect.
- R7: A blocked write changes no location. A blocked read, and any read in the reserved mode, returns 0x00. A reserved-mode write is blocked.
- R8: viol_o is 1 in the cycle after an access is blocked, and 0 in the cycle after a cycle with no blocked access. A blocked access is a blocked read with rd_en_i=1 or a blocked write with wr_en_i=1.
- R9: rd_data_o follows the read address combinationally from registered state. A write takes effect at the rising clock edge, so a read of the location being written in the same cycle returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| prot_en_i | input | 1 | Protect-window enable (bit 6 of the core's interrupt-mask byte) |
| rd_en_i | input | 1 | Read access valid (qualifies the violation report) |
| rd_addr_i | input | 8 | Read address or working-register number |
| rd_mode_i | input | 2 | Read addressing mode |
| rd_data_o | output | 8 | Read data, zero when blocked |
| wr_en_i | input | 1 | Write request |
| wr_addr_i | input | 8 | Write address or working-register number |
| wr_mode_i | input | 2 | Write addressing mode |
| wr_data_i | input | 8 | Write data |
| viol_o | output | 1 | One-cycle pulse after a blocked access |

## Verification
The hardest situation to reach is a working-mode access that lands in a restricted bank. Getting there first needs a direct write of the pointer to the right group, and then the protect state has to be set on the same cycle as the relocated access. The stimulus drives it in two ways. A directed sweep rewrites the pointer for each of the 16 groups and touches a register in each. Random traffic writes 0xFD often enough that later working-mode accesses land all over the space while the protect bit toggles. A reset in the middle of the run then shows that relocated writes made earlier are still in storage.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

    localparam int AW  = 8;
    localparam int DW  = 8;
    localparam int NIB = AW / 2;

    typedef logic [AW-1:0] addr_t;
    typedef logic [DW-1:0] data_t;

    typedef enum logic [1:0] {
        MODE_DIRECT = 2'b00,
        MODE_WORK   = 2'b01,
        MODE_INDIR  = 2'b10,
        MODE_RSVD   = 2'b11
    } mode_e;

    typedef struct packed {
        data_t ptr;
        data_t spare;
        data_t sp;
        logic  viol;
    } ctl_t;

endpackage

// File: rtl/wrf_resolve.sv
module wrf_resolve
    import wrf_pkg::*;
#(
    parameter addr_t WIN_LO = 8'h80,
    parameter addr_t WIN_HI = 8'hEF,
    parameter addr_t RSV_LO = 8'hE0,
    parameter addr_t RSV_HI = 8'hEF
) (
    input  addr_t              addr_i,
    input  logic [1:0]         mode_i,
    input  logic [NIB-1:0]     ptr_hi_i,
    input  logic               prot_i,
    output addr_t              eff_o,
    output logic               blk_o
);

    mode_e mode;
    logic  in_rsv;
    logic  in_win;

    always_comb begin
        mode = mode_e'(mode_i);
        // working numbers are relocated into the group picked by the pointer
        if (mode == MODE_WORK) begin
            eff_o = {ptr_hi_i, addr_i[NIB-1:0]};
        end else begin
            eff_o = addr_i;
        end
        in_rsv = (eff_o >= RSV_LO) && (eff_o <= RSV_HI);
        in_win = (eff_o >= WIN_LO) && (eff_o <= WIN_HI);
        blk_o  = (mode == MODE_RSVD)
              || ((mode == MODE_DIRECT) && in_rsv)
              || (prot_i && in_win);
    end

endmodule

// File: rtl/wrf_store.sv
module wrf_store
    import wrf_pkg::*;
#(
    parameter int DEPTH = 253,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [IDX_W-1:0] widx_i,
    input  data_t            wdata_i,
    input  logic [IDX_W-1:0] ridx_i,
    output data_t            rdata_o
);

    data_t mem_d [DEPTH];
    data_t mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we_i) begin
            mem_d[widx_i] = wdata_i;
        end
    end

    // no reset: contents persist across a core reset
    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rdata_o = mem_q[ridx_i];

endmodule

// File: rtl/wreg_file.sv
module wreg_file
    import wrf_pkg::*;
#(
    parameter addr_t WIN_LO     = 8'h80,
    parameter addr_t WIN_HI     = 8'hEF,
    parameter addr_t RSV_LO     = 8'hE0,
    parameter addr_t RSV_HI     = 8'hEF,
    parameter addr_t PTR_ADDR   = 8'hFD,
    parameter addr_t SPARE_ADDR = 8'hFE,
    parameter addr_t SP_ADDR    = 8'hFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prot_en_i,
    input  logic             rd_en_i,
    input  logic [AW-1:0]    rd_addr_i,
    input  logic [1:0]       rd_mode_i,
    output logic [DW-1:0]    rd_data_o,
    input  logic             wr_en_i,
    input  logic [AW-1:0]    wr_addr_i,
    input  logic [1:0]       wr_mode_i,
    input  logic [DW-1:0]    wr_data_i,
    output logic             viol_o
);

    localparam int DEPTH = int'(PTR_ADDR);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int NPORT = 2;
    localparam int P_RD  = 0;
    localparam int P_WR  = 1;

    ctl_t  ctl_d, ctl_q;

    addr_t      acc_addr [NPORT];
    logic [1:0] acc_mode [NPORT];
    addr_t      acc_eff  [NPORT];
    logic       acc_blk  [NPORT];

    logic              mem_we;
    logic [IDX_W-1:0]  mem_widx;
    logic [IDX_W-1:0]  mem_ridx;
    data_t             mem_rdata;
    data_t             rd_data;

    assign acc_addr[P_RD] = rd_addr_i;
    assign acc_mode[P_RD] = rd_mode_i;
    assign acc_addr[P_WR] = wr_addr_i;
    assign acc_mode[P_WR] = wr_mode_i;

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        wrf_resolve #(
            .WIN_LO (WIN_LO),
            .WIN_HI (WIN_HI),
            .RSV_LO (RSV_LO),
            .RSV_HI (RSV_HI)
        ) u_res (
            .addr_i   (acc_addr[g]),
            .mode_i   (acc_mode[g]),
            .ptr_hi_i (ctl_q.ptr[AW-1 -: NIB]),
            .prot_i   (prot_en_i),
            .eff_o    (acc_eff[g]),
            .blk_o    (acc_blk[g])
        );
    end

    assign mem_ridx = acc_eff[P_RD][IDX_W-1:0];
    assign mem_widx = acc_eff[P_WR][IDX_W-1:0];

    wrf_store #(
        .DEPTH (DEPTH)
    ) u_store (
        .clk     (clk),
        .we_i    (mem_we),
        .widx_i  (mem_widx),
        .wdata_i (wr_data_i),
        .ridx_i  (mem_ridx),
        .rdata_o (mem_rdata)
    );

    always_comb begin
        ctl_d  = ctl_q;
        mem_we = 1'b0;

        // read path: combinational from registered state
        rd_data = '0;
        if (!acc_blk[P_RD]) begin
            if (acc_eff[P_RD] == PTR_ADDR) begin
                rd_data = ctl_q.ptr;
            end else if (acc_eff[P_RD] == SPARE_ADDR) begin
                rd_data = ctl_q.spare;
            end else if (acc_eff[P_RD] == SP_ADDR) begin
                rd_data = ctl_q.sp;
            end else if (acc_eff[P_RD] < PTR_ADDR) begin
                rd_data = mem_rdata;
            end
        end

        // write path
        if (wr_en_i && !acc_blk[P_WR] && rst_n) begin
            if (acc_eff[P_WR] == PTR_ADDR) begin
                ctl_d.ptr = wr_data_i;
            end else if (acc_eff[P_WR] == SPARE_ADDR) begin
                ctl_d.spare = wr_data_i;
            end else if (acc_eff[P_WR] == SP_ADDR) begin
                ctl_d.sp = wr_data_i;
            end else if (acc_eff[P_WR] < PTR_ADDR) begin
                mem_we = 1'b1;
            end
        end

        ctl_d.viol = (rd_en_i && acc_blk[P_RD]) || (wr_en_i && acc_blk[P_WR]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rd_data_o = rd_data;
    assign viol_o    = ctl_q.viol;

endmodule

// File: rtl/wreg_file_chk.sv
module wreg_file_chk #(
    parameter logic [7:0] WIN_LO = 8'h80,
    parameter logic [7:0] WIN_HI = 8'hEF,
    parameter logic [7:0] RSV_LO = 8'hE0,
    parameter logic [7:0] RSV_HI = 8'hEF
) (
    input logic       clk,
    input logic       rst_n,
    input logic       prot,
    input logic       rd_en,
    input logic [7:0] rd_addr,
    input logic [1:0] rd_mode,
    input logic [7:0] rd_data,
    input logic       wr_en,
    input logic       rd_blk,
    input logic       wr_blk,
    input logic [7:0] ptr,
    input logic [7:0] spare,
    input logic       viol
);

    AST_CTL_CLEAR_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ptr == 8'h00) && (spare == 8'h00)); // R3

    AST_DIRECT_BANK_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_mode == 2'b00) && (rd_addr >= RSV_LO) && (rd_addr <= RSV_HI)
        |-> rd_data == 8'h00); // R5

    AST_WINDOW_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        prot && (rd_mode != 2'b01) && (rd_addr >= WIN_LO) && (rd_addr <= WIN_HI)
        |-> rd_data == 8'h00); // R6

    AST_RSVD_MODE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_mode == 2'b11) |-> rd_data == 8'h00); // R7

    AST_BLOCKED_WRITE_KEEPS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_blk |=> $stable(ptr) && $stable(spare)); // R7

    AST_VIOL_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_blk) || (wr_en && wr_blk) |=> viol); // R8

    AST_VIOL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !((rd_en && rd_blk) || (wr_en && wr_blk)) |=> !viol); // R8

endmodule

bind wreg_file wreg_file_chk #(
    .WIN_LO (WIN_LO),
    .WIN_HI (WIN_HI),
    .RSV_LO (RSV_LO),
    .RSV_HI (RSV_HI)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .prot    (prot_en_i),
    .rd_en   (rd_en_i),
    .rd_addr (rd_addr_i),
    .rd_mode (rd_mode_i),
    .rd_data (rd_data_o),
    .wr_en   (wr_en_i),
    .rd_blk  (acc_blk[0]),
    .wr_blk  (acc_blk[1]),
    .ptr     (ctl_q.ptr),
    .spare   (ctl_q.spare),
    .viol    (viol_o)
);

// File: tb/wreg_file_tb.sv
`timescale 1ns/1ps
module wreg_file_tb;

    localparam logic [1:0] M_DIR = 2'b00;
    localparam logic [1:0] M_WRK = 2'b01;
    localparam logic [1:0] M_IND = 2'b10;
    localparam logic [1:0] M_RSV = 2'b11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prot_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_addr = '0;
    logic [1:0] rd_mode = '0;
    logic [7:0] rd_data;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [1:0] wr_mode = '0;
    logic [7:0] wr_data = '0;
    logic       viol;

    always #10 clk = ~clk;

    wreg_file u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .prot_en_i (prot_en),
        .rd_en_i   (rd_en),
        .rd_addr_i (rd_addr),
        .rd_mode_i (rd_mode),
        .rd_data_o (rd_data),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_mode_i (wr_mode),
        .wr_data_i (wr_data),
        .viol_o    (viol)
    );

    // reference state
    logic [7:0] m_mem [256];
    logic [7:0] m_ptr = '0, m_spare = '0, m_sp = '0;
    logic       exp_viol = 1'b0;
    logic       cur_prot = 1'b0;
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    function automatic logic [7:0] f_eff(logic [7:0] a, logic [1:0] m);
        return (m == M_WRK) ? {m_ptr[7:4], a[3:0]} : a;
    endfunction

    function automatic logic f_blk(logic [7:0] a, logic [1:0] m, logic p);
        logic [7:0] e = f_eff(a, m);
        if (m == M_RSV) return 1'b1;
        if (m == M_DIR && e >= 8'hE0 && e <= 8'hEF) return 1'b1;
        if (p && e >= 8'h80 && e <= 8'hEF) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [7:0] f_read(logic [7:0] a, logic [1:0] m, logic p);
        logic [7:0] e = f_eff(a, m);
        if (f_blk(a, m, p)) return 8'h00;
        case (e)
            8'hFD:   return m_ptr;
            8'hFE:   return m_spare;
            8'hFF:   return m_sp;
            default: return m_mem[e];
        endcase
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_op(bit re, logic [7:0] ra, logic [1:0] rm,
                         bit we, logic [7:0] wa, logic [1:0] wm, logic [7:0] wd,
                         string tag);
        string req;
        logic [7:0] e;
        @(negedge clk);
        check("R8", {7'd0, viol}, {7'd0, exp_viol});
        prot_en = cur_prot;
        rd_en = re; rd_addr = ra; rd_mode = rm;
        wr_en = we; wr_addr = wa; wr_mode = wm; wr_data = wd;
        #1;
        if (re) begin
            if (tag != "")                   req = tag;
            else if (f_blk(ra, rm, cur_prot)) req = "R7";
            else if (rm == M_WRK)             req = "R2";
            else                              req = "R1";
            check(req, rd_data, f_read(ra, rm, cur_prot));
        end
        exp_viol = (re && f_blk(ra, rm, cur_prot)) || (we && f_blk(wa, wm, cur_prot));
        if (we && !f_blk(wa, wm, cur_prot)) begin
            e = f_eff(wa, wm);
            case (e)
                8'hFD:   m_ptr = wd;
                8'hFE:   m_spare = wd;
                8'hFF:   m_sp = wd;
                default: m_mem[e] = wd;
            endcase
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_ptr = '0; m_spare = '0; m_sp = '0; exp_viol = 1'b0;
    endtask

    function automatic logic [1:0] rnd_mode();
        int k = $urandom % 8;
        if (k < 3) return M_DIR;
        if (k < 6) return M_WRK;
        if (k < 7) return M_IND;
        return M_RSV;
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) m_mem[i] = '0;
        do_reset();

        // reset state of control bytes
        do_op(1, 8'hFD, M_DIR, 0, 8'h00, M_DIR, 8'h00, "R3");
        do_op(1, 8'hFE, M_DIR, 0, 8'h00, M_DIR, 8'h00, "R3");
        do_op(1, 8'hFF, M_IND, 0, 8'h00, M_DIR, 8'h00, "R3");

        // fill storage through indirect mode so every location is known
        for (int a = 0; a < 253; a++)
            do_op(0, 8'h00, M_DIR, 1, a[7:0], M_IND, 8'($urandom), "");

        // working-mode relocation across all 16 groups
        for (int g = 0; g < 16; g++) begin
            logic [3:0] r = 4'(g) ^ 4'h5;
            do_op(0, 8'h00, M_DIR, 1, 8'hFD, M_DIR, {4'(g), 4'h0}, "");
            do_op(1, 8'hFD, M_DIR, 1, {4'h0, r}, M_WRK, 8'(g * 17 + 3), "R3");
            do_op(1, {4'(g), r}, M_IND, 0, 8'h00, M_DIR, 8'h00, "R2");
            do_op(1, {4'hA, r}, M_WRK, 0, 8'h00, M_DIR, 8'h00, "R2");
            if (g == 14) begin
                do_op(1, {4'(g), r}, M_DIR, 0, 8'h00, M_DIR, 8'h00, "R5");
                do_op(0, 8'h00, M_DIR, 1, {4'(g), r}, M_DIR, 8'h5A, "R5");
                do_op(1, {4'(g), r}, M_IND, 0, 8'h00, M_DIR, 8'h00, "R5");
            end
        end

        // protect window boundaries, then window off
        for (int p = 1; p >= 0; p--) begin
            cur_prot = p[0];
            do_op(0, 8'h00, M_DIR, 1, 8'h7F, M_DIR, 8'h11, "");
            do_op(1, 8'h7F, M_DIR, 1, 8'h80, M_DIR, 8'h22, "R6");
            do_op(1, 8'h80, M_DIR, 1, 8'hEF, M_IND, 8'h33, "R6");
            do_op(1, 8'hEF, M_IND, 1, 8'hF0, M_DIR, 8'h44, "R6");
            do_op(1, 8'hF0, M_DIR, 0, 8'h00, M_DIR, 8'h00, "R6");
            do_op(1, 8'h80, M_IND, 0, 8'h00, M_DIR, 8'h00, "R6");
        end

        // same-cycle write and read return the old value, then the new one
        do_op(1, 8'h33, M_IND, 1, 8'h33, M_IND, 8'hA5, "R9");
        do_op(1, 8'h33, M_DIR, 0, 8'h00, M_DIR, 8'h00, "R9");

        // reserved mode
        do_op(1, 8'h10, M_RSV, 1, 8'h10, M_RSV, 8'hEE, "R7");
        do_op(1, 8'h10, M_DIR, 0, 8'h00, M_DIR, 8'h00, "R7");

        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] wa;
            if (i % 64 == 0) cur_prot = 1'($urandom);
            wa = ($urandom % 8 == 0) ? 8'hFD : 8'($urandom);
            do_op(1'($urandom), 8'($urandom), rnd_mode(),
                  1'($urandom), wa, rnd_mode(), 8'($urandom), "");
        end

        // storage survives reset, control bytes clear
        cur_prot = 1'b0;
        do_op(0, 8'h00, M_DIR, 1, 8'hFE, M_DIR, 8'h9C, "");
        do_op(0, 8'h00, M_DIR, 1, 8'hFD, M_DIR, 8'h70, "");
        do_reset();
        do_op(1, 8'hFD, M_DIR, 0, 8'h00, M_DIR, 8'h00, "R3");
        do_op(1, 8'hFE, M_DIR, 0, 8'h00, M_DIR, 8'h00, "R3");
        for (int a = 0; a < 253; a++)
            do_op(1, a[7:0], M_IND, 0, 8'h00, M_DIR, 8'h00, "R4");
        do_op(0, 8'h00, M_DIR, 0, 8'h00, M_DIR, 8'h00, "");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule